// File: doc/BRIEF.md
# Pixel Thermometer Encoder and Column Projection

This block is the digital back end of a small pixel matrix. Every pixel delivers a three-bit thermometer word from its flash comparators. In normal operation each word becomes a two-bit count, and the counts of all pixels that share a column are added together. One projection sum per column comes out, and the row position is dropped. The encode-and-add path has no registers. A single register on the event clock stands in for the classifier that consumes the sums, so the projection refreshes once per event.

For characterisation a test mode is provided. The raw thermometer bits of every pixel, not the encoded counts, are captured in parallel into a scan register. They are then shifted out one bit at a time on a separate capture clock. While test mode is active the projection register keeps its last value. While normal mode is active the scan register keeps its contents. The projection output is a plain registered bus with no handshake, because the detector cannot be stalled and a new event arrives on every event clock.

Top module: `pixproj_top`

## Requirements
- R1: Pixel p occupies `pix_therm[3p+2:3p]`, with bit 3p the lowest threshold. Pixel p lies in row p/16 and column p%16. The well-formed words 000, 001, 011 and 111 encode to 0, 1, 2 and 3.
- R2: A word that is not a valid thermometer pattern (for example 101, 100, 110 or 010) encodes to the number of bits set in it, so the code never exceeds 3.
- R3: Column c's sum is the total of the codes of the sixteen pixels in that column and appears on `proj_sum[6c+5:6c]`. The largest sum is 48, which fits in six bits without wrap.
- R4: With `test_mode` low, every rising `evt_clk` edge loads `proj_sum` with the projection of the `pix_therm` value present at that edge. There is exactly one register of latency.
- R5: With `test_mode` high at a rising `evt_clk` edge, `proj_sum` keeps its value regardless of `pix_therm`.
- R6: While `rst_n` is low, and after it is released, `proj_sum` reads zero and the scan register is empty, so `scan_out` is 0 until a load.
- R7: With `test_mode` high and `scan_load` high at a rising `cap_clk` edge, all 768 raw thermometer bits are captured unencoded. Afterwards `scan_out` shows `pix_therm[0]`.
- R8: With `test_mode` high and `scan_load` low, each rising `cap_clk` edge moves the register one place toward `scan_out`, and a 0 enters at the far end. After k shifts, `scan_out` shows the captured `pix_therm[k]`. The order is pixel 0 bit 0, pixel 0 bit 1, pixel 0 bit 2, pixel 1 bit 0, and so on. After 768 shifts it reads 0.
- R9: With `test_mode` low, the scan register neither loads nor shifts on `cap_clk` edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| evt_clk | input | 1 | Event clock; registers the projection |
| cap_clk | input | 1 | Capture clock; drives the scan register |
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| test_mode | input | 1 | 1 selects scan operation and freezes the projection |
| scan_load | input | 1 | In test mode: 1 parallel capture, 0 shift by one |
| pix_therm | input | 768 | Thermometer words of all 256 pixels, three bits each |
| proj_sum | output | 96 | Sixteen registered six-bit column sums |
| scan_out | output | 1 | Serial output of the scan register |

## Verification
The bench builds the block with its default 16 by 16 geometry and three-bit words. This puts the full 48 column sum in reach with an all-ones frame. It also lets the complete 768-position scan walk be compared bit by bit, including the zero that follows the last bit. A scoreboard queues the expected sums for each event and compares them one edge later. The frames cover each legal code in isolation, malformed words, the last pixel of the last column, and random frames. Queued hold items cover frozen frames in test mode. The scan checks then capture a frame, walk it out, and confirm that the register state survives a stretch of normal mode.

// File: rtl/pixproj_pkg.sv
package pixproj_pkg;

  typedef enum logic {
    SCAN_SHIFT = 1'b0,
    SCAN_LOAD  = 1'b1
  } scan_op_e;

endpackage

// File: rtl/pix_encoder.sv
module pix_encoder #(
  parameter int N_PIX  = 256,
  parameter int TBITS  = 3,
  parameter int CODE_W = $clog2(TBITS + 1)
) (
  input  logic [N_PIX*TBITS-1:0]  therm_in,
  output logic [N_PIX*CODE_W-1:0] code_out
);

  for (genvar p = 0; p < N_PIX; p++) begin : g_pix
    logic [CODE_W-1:0] cnt;
    // Counting set bits gives the thermometer value for legal words
    // and a bounded value for malformed ones (R1, R2).
    always_comb begin
      cnt = '0;
      for (int b = 0; b < TBITS; b++) begin
        cnt = cnt + CODE_W'(therm_in[p*TBITS+b]);
      end
    end
    assign code_out[p*CODE_W +: CODE_W] = cnt;
  end

endmodule

// File: rtl/col_projector.sv
module col_projector #(
  parameter int N_ROWS = 16,
  parameter int N_COLS = 16,
  parameter int CODE_W = 2,
  parameter int SUM_W  = 6
) (
  input  logic [N_ROWS*N_COLS*CODE_W-1:0] code_in,
  output logic [N_COLS*SUM_W-1:0]         sum_out
);

  for (genvar c = 0; c < N_COLS; c++) begin : g_col
    logic [SUM_W-1:0] acc;
    // Row index is folded away; column index is kept (R3).
    always_comb begin
      acc = '0;
      for (int r = 0; r < N_ROWS; r++) begin
        acc = acc + SUM_W'(code_in[(r*N_COLS+c)*CODE_W +: CODE_W]);
      end
    end
    assign sum_out[c*SUM_W +: SUM_W] = acc;
  end

endmodule

// File: rtl/scan_chain.sv
module scan_chain
  import pixproj_pkg::*;
#(
  parameter int W = 768
) (
  input  logic         cap_clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         load,
  input  logic [W-1:0] par_in,
  output logic         ser_out
);

  logic [W-1:0] chain_q;
  scan_op_e     op;

  assign op = load ? SCAN_LOAD : SCAN_SHIFT;

  always_ff @(posedge cap_clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else if (enable) begin
      case (op)
        SCAN_LOAD:  chain_q <= par_in;
        SCAN_SHIFT: chain_q <= {1'b0, chain_q[W-1:1]};
        default:    chain_q <= chain_q;
      endcase
    end
  end

  assign ser_out = chain_q[0];

  p_scan_load_r7: assert property (@(posedge cap_clk) disable iff (!rst_n)
    (enable && load) |=> (chain_q == $past(par_in)));

  p_scan_shift_r8: assert property (@(posedge cap_clk) disable iff (!rst_n)
    (enable && !load) |=> ((chain_q[W-2:0] == $past(chain_q[W-1:1])) && !chain_q[W-1]));

  p_scan_hold_r9: assert property (@(posedge cap_clk) disable iff (!rst_n)
    !enable |=> $stable(chain_q));

endmodule

// File: rtl/pixproj_top.sv
module pixproj_top #(
  parameter int N_ROWS = 16,
  parameter int N_COLS = 16,
  parameter int TBITS  = 3
) (
  input  logic                                     evt_clk,
  input  logic                                     cap_clk,
  input  logic                                     rst_n,
  input  logic                                     test_mode,
  input  logic                                     scan_load,
  input  logic [N_ROWS*N_COLS*TBITS-1:0]           pix_therm,
  output logic [N_COLS*$clog2(N_ROWS*TBITS+1)-1:0] proj_sum,
  output logic                                     scan_out
);

  localparam int N_PIX   = N_ROWS * N_COLS;
  localparam int CODE_W  = $clog2(TBITS + 1);
  localparam int MAX_SUM = N_ROWS * TBITS;
  localparam int SUM_W   = $clog2(MAX_SUM + 1);
  localparam int SCAN_W  = N_PIX * TBITS;

  logic [N_PIX*CODE_W-1:0] codes;
  logic [N_COLS*SUM_W-1:0] proj_comb;
  logic [N_COLS*SUM_W-1:0] proj_q;

  pix_encoder #(
    .N_PIX (N_PIX),
    .TBITS (TBITS),
    .CODE_W(CODE_W)
  ) u_enc (
    .therm_in(pix_therm),
    .code_out(codes)
  );

  col_projector #(
    .N_ROWS(N_ROWS),
    .N_COLS(N_COLS),
    .CODE_W(CODE_W),
    .SUM_W (SUM_W)
  ) u_proj (
    .code_in(codes),
    .sum_out(proj_comb)
  );

  // Stand-in for the downstream classifier's input register (R4, R5).
  always_ff @(posedge evt_clk or negedge rst_n) begin
    if (!rst_n) begin
      proj_q <= '0;
    end else if (!test_mode) begin
      proj_q <= proj_comb;
    end
  end

  assign proj_sum = proj_q;

  scan_chain #(
    .W(SCAN_W)
  ) u_scan (
    .cap_clk(cap_clk),
    .rst_n  (rst_n),
    .enable (test_mode),
    .load   (scan_load),
    .par_in (pix_therm),
    .ser_out(scan_out)
  );

  p_proj_tracks_r4: assert property (@(posedge evt_clk) disable iff (!rst_n)
    !test_mode |=> (proj_q == $past(proj_comb)));

  p_proj_hold_r5: assert property (@(posedge evt_clk) disable iff (!rst_n)
    test_mode |=> $stable(proj_q));

  for (genvar c = 0; c < N_COLS; c++) begin : g_chk
    p_no_overflow_r3: assert property (@(posedge evt_clk) disable iff (!rst_n)
      proj_q[c*SUM_W +: SUM_W] <= SUM_W'(MAX_SUM));
  end

endmodule

// File: tb/pixproj_top_tb_top.sv
`timescale 1ns/100ps
module pixproj_top_tb_top;

  localparam int NR = 16;
  localparam int NC = 16;
  localparam int NP = NR * NC;
  localparam int SW = 6;
  localparam int W  = NP * 3;

  logic          evt_clk = 1'b0;
  logic          cap_clk = 1'b0;
  logic          rst_n;
  logic          test_mode;
  logic          scan_load;
  logic [W-1:0]  pix_therm;
  logic [NC*SW-1:0] proj_sum;
  logic          scan_out;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [NC*SW-1:0] exp_q[$];
  string            tag_q[$];
  logic [NC*SW-1:0] last_exp;

  pixproj_top dut_i (
    .evt_clk  (evt_clk),
    .cap_clk  (cap_clk),
    .rst_n    (rst_n),
    .test_mode(test_mode),
    .scan_load(scan_load),
    .pix_therm(pix_therm),
    .proj_sum (proj_sum),
    .scan_out (scan_out)
  );

  always #2 evt_clk = ~evt_clk;
  initial begin
    #1;
    forever #2 cap_clk = ~cap_clk;
  end

  task automatic chk(input bit ok, input string tag, input logic [NC*SW-1:0] act,
                     input logic [NC*SW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected sums from R1-style counting of set bits per pixel word.
  function automatic logic [NC*SW-1:0] model(input logic [W-1:0] p);
    logic [NC*SW-1:0] r = '0;
    for (int c = 0; c < NC; c++) begin
      int s = 0;
      for (int row = 0; row < NR; row++) begin
        int idx = row * NC + c;
        s += int'(p[3*idx]) + int'(p[3*idx+1]) + int'(p[3*idx+2]);
      end
      r[c*SW +: SW] = SW'(s);
    end
    return r;
  endfunction

  task automatic drive_frame(input logic [W-1:0] p, input string tag);
    @(negedge evt_clk);
    test_mode = 1'b0;
    scan_load = 1'b0;
    pix_therm = p;
    last_exp  = model(p);
    exp_q.push_back(last_exp);
    tag_q.push_back(tag);
  endtask

  task automatic drive_hold(input logic [W-1:0] p);
    @(negedge evt_clk);
    test_mode = 1'b1;
    scan_load = 1'b0;
    pix_therm = p;
    exp_q.push_back(last_exp);
    tag_q.push_back("R5 hold in test mode");
  endtask

  // Monitor: one queued item per event edge after it was driven.
  always @(posedge evt_clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [NC*SW-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(proj_sum === e, t, proj_sum, e);
    end
  end

  function automatic logic [W-1:0] rand_frame(input bit legal);
    logic [W-1:0] f;
    for (int p = 0; p < NP; p++) begin
      int v = int'($urandom_range(0, 7));
      if (legal) begin
        case (v % 4)
          0: f[3*p +: 3] = 3'b000;
          1: f[3*p +: 3] = 3'b001;
          2: f[3*p +: 3] = 3'b011;
          default: f[3*p +: 3] = 3'b111;
        endcase
      end else begin
        f[3*p +: 3] = 3'(v);
      end
    end
    return f;
  endfunction

  initial begin
    logic [W-1:0] f;
    logic [W-1:0] pat;
    logic [NC*SW-1:0] frozen;
    rst_n = 1'b0;
    test_mode = 1'b0;
    scan_load = 1'b0;
    pix_therm = '1;
    last_exp = '0;
    repeat (3) @(posedge evt_clk);
    #1;
    chk(proj_sum === '0, "R6 proj during reset", proj_sum, '0);
    chk(scan_out === 1'b0, "R6 scan_out during reset", {95'd0, scan_out}, '0);
    @(negedge evt_clk);
    pix_therm = '0;
    rst_n = 1'b1;
    @(posedge evt_clk);
    #1;
    chk(proj_sum === '0, "R6 proj after reset", proj_sum, '0);
    chk(scan_out === 1'b0, "R6 scan_out after reset", {95'd0, scan_out}, '0);

    // R1: each legal code alone in pixel 0 (column 0).
    f = '0; f[2:0] = 3'b001; drive_frame(f, "R1 code 001 -> 1");
    f = '0; f[2:0] = 3'b011; drive_frame(f, "R1 code 011 -> 2");
    f = '0; f[2:0] = 3'b111; drive_frame(f, "R1 code 111 -> 3");
    // R2: malformed words.
    f = '0; f[2:0] = 3'b101; drive_frame(f, "R2 code 101 -> 2");
    f = '0; f[2:0] = 3'b100; drive_frame(f, "R2 code 100 -> 1");
    f = '0; f[2:0] = 3'b110; f[5:3] = 3'b010; drive_frame(f, "R2 codes 110,010");
    // R3: last pixel (row 15, column 15) and full-scale frame.
    f = '0; f[W-1 -: 3] = 3'b111; drive_frame(f, "R3 last column");
    drive_frame('1, "R3 max sum 48");
    drive_frame('0, "R4 all zero");
    for (int i = 0; i < 6; i++) drive_frame(rand_frame(1'b1), "R4 random legal");
    for (int i = 0; i < 6; i++) drive_frame(rand_frame(1'b0), "R2 random mixed");
    for (int i = 0; i < 3; i++) drive_hold(rand_frame(1'b0));
    drive_frame(rand_frame(1'b1), "R4 resume after hold");
    repeat (3) @(posedge evt_clk);

    // Scan: capture raw bits, walk them out.
    frozen = proj_sum;
    pat = rand_frame(1'b0);
    pat[0] = 1'b1;
    pat[1] = 1'b0;
    @(negedge evt_clk);
    test_mode = 1'b1;
    scan_load = 1'b1;
    pix_therm = pat;
    @(posedge cap_clk); #1;
    chk(scan_out === pat[0], "R7 load shows bit 0", {95'd0, scan_out}, {95'd0, pat[0]});
    scan_load = 1'b0;
    pix_therm = ~pat;
    for (int k = 1; k < W; k++) begin
      @(posedge cap_clk); #1;
      chk(scan_out === pat[k], $sformatf("R8 shift bit %0d", k),
          {95'd0, scan_out}, {95'd0, pat[k]});
    end
    @(posedge cap_clk); #1;
    chk(scan_out === 1'b0, "R8 empty after full walk", {95'd0, scan_out}, '0);
    chk(proj_sum === frozen, "R5 proj frozen during scan", proj_sum, frozen);

    // R9: reload, then normal mode must not touch the register.
    scan_load = 1'b1;
    pix_therm = pat;
    @(posedge cap_clk); #1;
    test_mode = 1'b0;
    scan_load = 1'b0;
    repeat (3) @(posedge cap_clk);
    #1;
    chk(scan_out === 1'b1, "R9 no shift in normal mode", {95'd0, scan_out}, 96'd1);
    scan_load = 1'b1;
    pix_therm = '0;
    repeat (2) @(posedge cap_clk);
    #1;
    chk(scan_out === 1'b1, "R9 no load in normal mode", {95'd0, scan_out}, 96'd1);
    test_mode = 1'b1;
    scan_load = 1'b0;
    @(posedge cap_clk); #1;
    chk(scan_out === pat[1], "R9 state kept, next bit", {95'd0, scan_out}, {95'd0, pat[1]});
    test_mode = 1'b0;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule